// File: doc/BRIEF.md
# EPP Parallel Port Cycle Controller

This block is the chip-side sequencer for enhanced parallel port data and address transfers. A host I/O cycle (read or write strobe plus a select and an address/data target bit) is turned into a peripheral handshake. The handshake has a bus-direction line, an active-low write marker, one of two active-low strobes and a byte-wide bus output enable. The peripheral answers on an active-low wait line. While that line stays low, the host cycle is stretched through an active-low ready output.

The wait line passes through a two-stage synchroniser, and the design acts on its rising edge. A read byte is captured from the peripheral bus on that edge and presented to the host until the host ends its command. A programmable counter, started when the strobe falls, bounds the wait. When the counter expires, the host is released, a sticky flag is raised and an all-ones byte is returned. The strobe stays low until the host drops its command. Outputs then return to rest so the next cycle can be prepared.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low: both strobes are high, `host_rdy` is 1, `pd_oe` is 0, `pp_wr_n` is 1, `to_sticky` is 0 and `pp_init_n` is 0.
- R2: A cycle starts when `host_sel` is 1 and `host_rd_n` or `host_wr_n` is low. A read takes priority when both are low. Exactly one setup cycle follows, with both strobes high. Then `pp_astb_n` goes low if `host_is_addr` was 1 at the start, and `pp_dstb_n` goes low otherwise, never both.
- R3: In a write cycle with `dir_bit` 0, `pp_wr_n` goes low and `pd_out` carries `host_wdata` with `pd_oe` 1 from the setup cycle on. This is one cycle before the strobe falls, and `pp_wr_n` never changes on the edge where a strobe falls. The drive holds until the strobe is released.
- R4: `host_rdy` is 0 from the setup cycle until the state after the wait event. Counting the first strobe-low cycle as index 0, with the wait line raised at index d and timeout limit L, `host_rdy` returns to 1 at index min(L+1, d+3).
- R5: In a read, `pd_in` is captured when the synchronised wait line rises. The captured byte appears on `host_rdata` from the moment `host_rdy` returns until the command ends. `host_rdata` is 0 at all other times.
- R6: If the wait line has not risen by index L, the cycle completes anyway. `to_sticky` is then set, and a read returns 8'hFF.
- R7: When the wait rise and the timeout fall on the same cycle (L = d+2), the rise wins: the real data is returned and `to_sticky` stays 0.
- R8: The active strobe stays low until both `host_rd_n` and `host_wr_n` are high. On the next sample, both strobes are high, `pd_oe` is 0, `pp_wr_n` is 1, `host_rdy` is 1 and `host_rdata` is 0.
- R9: `to_sticky` stays set across later cycles until a cycle with `to_clear` high clears it.
- R10: `pp_rx_dir` is 1 whenever `dir_bit` is 1 or a read cycle is active, and 0 otherwise. With `dir_bit` 1 at the start of a write, `pd_oe` stays 0 and `pp_wr_n` stays 1 while the strobe handshake still runs.
- R11: Host commands are ignored while `host_sel` is 0: no strobe falls and `host_rdy` stays 1.
- R12: `pp_init_n` is the registered inverse of `init_req`, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host cycle targets this port |
| host_is_addr | input | 1 | 1 selects the address register, 0 the data register |
| host_rd_n | input | 1 | Host read command, active low |
| host_wr_n | input | 1 | Host write command, active low |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Read byte for the host |
| host_rdy | output | 1 | Host ready, 0 stretches the cycle |
| dir_bit | input | 1 | Control-register direction, 1 means input |
| init_req | input | 1 | Request to reset the peripheral |
| to_limit | input | TW | Timeout limit in clocks |
| to_clear | input | 1 | Clears the sticky timeout flag |
| to_sticky | output | 1 | Sticky timeout flag |
| pd_in | input | DW | Peripheral bus input |
| pd_out | output | DW | Peripheral bus output value |
| pd_oe | output | 1 | Peripheral bus output enable |
| pp_wr_n | output | 1 | Write marker, active low |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_wait_n | input | 1 | Peripheral wait line, asynchronous |
| pp_rx_dir | output | 1 | Bus direction, 1 means input |
| pp_init_n | output | 1 | Peripheral reset, active low |

## Verification
The synchronised wait rise and the timeout expiry can land on the same clock, and the design must then pick exactly one outcome. The bench provokes this by sweeping the delay d of the wait rise against the limit L over every pairing in a small grid. For each pairing it predicts the release index min(L+1, d+3) arithmetically. The diagonal L = d+2 is judged by requiring the real data byte, a clear sticky flag and release at the shared index.

// File: rtl/epp_ctl_pkg.sv
`timescale 1ns/1ps
package epp_ctl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_HOLD   = 2'd3
   } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
`timescale 1ns/1ps
module epp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("epp_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_timer.sv
`timescale 1ns/1ps
module epp_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   generate
      if (TW < 1) begin : g_bad
         $error("epp_timer width must be positive");
      end
   endgenerate

   localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

   logic [TW-1:0] cnt;
   logic          run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         run_q <= 1'b0;
      end else begin
         run_q <= run;
         if (!run)               cnt <= '0;
         else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && (cnt == limit);

   // R4: counting starts from zero on the first strobe cycle
   assert_count_starts_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !run_q) |-> (cnt == '0));
endmodule

// File: rtl/epp_cycle_fsm.sv
`timescale 1ns/1ps
module epp_cycle_fsm
   import epp_ctl_pkg::*;
#(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] BAD_BYTE = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_is_addr,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic [DW-1:0] host_wdata,
   input  logic          dir_bit,
   input  logic [DW-1:0] pd_in,
   input  logic          wait_rise,
   input  logic          expired,
   input  logic          to_clear,
   output logic          strobe_phase,
   output logic [DW-1:0] host_rdata,
   output logic          host_rdy,
   output logic [DW-1:0] pd_out,
   output logic          pd_oe,
   output logic          pp_wr_n,
   output logic          pp_dstb_n,
   output logic          pp_astb_n,
   output logic          pp_rx_dir,
   output logic          to_sticky
);
   epp_state_e    state;
   logic          cyc_rd;
   logic          cyc_adr;
   logic          cyc_drv;
   logic [DW-1:0] wr_q;
   logic [DW-1:0] rd_q;
   logic          sticky;
   logic          start_rq;
   logic          host_idle;
   logic          give_up;

   assign start_rq  = host_sel && (!host_rd_n || !host_wr_n);
   assign host_idle = host_rd_n && host_wr_n;
   assign give_up   = (state == ST_STROBE) && !wait_rise && expired;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cyc_rd  <= 1'b0;
         cyc_adr <= 1'b0;
         cyc_drv <= 1'b0;
         wr_q    <= '0;
         rd_q    <= '0;
         sticky  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_rq) begin
                  cyc_rd  <= !host_rd_n;
                  cyc_adr <= host_is_addr;
                  cyc_drv <= host_rd_n && !dir_bit;
                  wr_q    <= host_wdata;
                  state   <= ST_SETUP;
               end
            end
            ST_SETUP: state <= ST_STROBE;
            ST_STROBE: begin
               if (wait_rise) begin
                  rd_q  <= pd_in;
                  state <= ST_HOLD;
               end else if (expired) begin
                  rd_q  <= BAD_BYTE;
                  state <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (host_idle) begin
                  state   <= ST_IDLE;
                  cyc_drv <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (give_up)       sticky <= 1'b1;
         else if (to_clear) sticky <= 1'b0;
      end
   end

   logic active;
   logic stb_on;
   logic drive;

   assign active       = (state != ST_IDLE);
   assign stb_on       = (state == ST_STROBE) || (state == ST_HOLD);
   assign drive        = active && cyc_drv;
   assign strobe_phase = (state == ST_STROBE);

   assign pp_rx_dir  = dir_bit || (active && cyc_rd);
   assign pd_oe      = drive;
   assign pp_wr_n    = !drive;
   assign pd_out     = drive ? wr_q : '0;
   assign pp_dstb_n  = !(stb_on && !cyc_adr);
   assign pp_astb_n  = !(stb_on && cyc_adr);
   assign host_rdy   = !((state == ST_SETUP) || (state == ST_STROBE));
   assign host_rdata = ((state == ST_HOLD) && cyc_rd) ? rd_q : '0;
   assign to_sticky  = sticky;

   logic any_stb_n;
   assign any_stb_n = pp_dstb_n && pp_astb_n;

   // R3: write marker is settled before the strobe falls
   assert_wr_steady_at_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_stb_n && $past(any_stb_n)) |-> (pp_wr_n == $past(pp_wr_n)));

   // R8: a strobe is released only after the host command ended
   assert_release_after_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stb_n && !$past(any_stb_n)) |-> $past(host_idle));

   // R10: no bus drive while direction says input
   assert_no_drive_when_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pp_rx_dir |-> !pd_oe);

   // R6: timeout flag rises only out of a stretched host cycle
   assert_sticky_from_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_sticky) |-> $past(!host_rdy));

   // R2: never both strobes at once
   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!pp_dstb_n && !pp_astb_n));
endmodule

// File: rtl/epp_cycle_ctrl.sv
`timescale 1ns/1ps
module epp_cycle_ctrl #(
   parameter int DW          = 8,
   parameter int TW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_is_addr,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_rdy,
   input  logic          dir_bit,
   input  logic          init_req,
   input  logic [TW-1:0] to_limit,
   input  logic          to_clear,
   output logic          to_sticky,
   input  logic [DW-1:0] pd_in,
   output logic [DW-1:0] pd_out,
   output logic          pd_oe,
   output logic          pp_wr_n,
   output logic          pp_dstb_n,
   output logic          pp_astb_n,
   input  logic          pp_wait_n,
   output logic          pp_rx_dir,
   output logic          pp_init_n
);
   localparam logic [DW-1:0] BAD_BYTE = {DW{1'b1}};

   generate
      if (DW < 1 || TW < 1) begin : g_bad
         $error("epp_cycle_ctrl widths must be positive");
      end
   endgenerate

   logic wait_s;
   logic wait_prev;
   logic wait_rise;
   logic expired;
   logic strobe_phase;
   logic init_q;

   epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pp_wait_n),
      .q     (wait_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_prev <= 1'b1;
         init_q    <= 1'b0;
      end else begin
         wait_prev <= wait_s;
         init_q    <= !init_req;
      end
   end

   assign wait_rise = wait_s && !wait_prev;
   assign pp_init_n = init_q;

   epp_timer #(.TW(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (strobe_phase),
      .limit   (to_limit),
      .expired (expired)
   );

   epp_cycle_fsm #(.DW(DW), .BAD_BYTE(BAD_BYTE)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_sel     (host_sel),
      .host_is_addr (host_is_addr),
      .host_rd_n    (host_rd_n),
      .host_wr_n    (host_wr_n),
      .host_wdata   (host_wdata),
      .dir_bit      (dir_bit),
      .pd_in        (pd_in),
      .wait_rise    (wait_rise),
      .expired      (expired),
      .to_clear     (to_clear),
      .strobe_phase (strobe_phase),
      .host_rdata   (host_rdata),
      .host_rdy     (host_rdy),
      .pd_out       (pd_out),
      .pd_oe        (pd_oe),
      .pp_wr_n      (pp_wr_n),
      .pp_dstb_n    (pp_dstb_n),
      .pp_astb_n    (pp_astb_n),
      .pp_rx_dir    (pp_rx_dir),
      .to_sticky    (to_sticky)
   );

   // R12: peripheral reset line follows the request one clock later
   assert_init_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pp_init_n == !$past(init_req)));
endmodule

// File: tb/epp_cycle_ctrl_test.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_sel, host_is_addr, host_rd_n, host_wr_n;
   logic [DW-1:0] host_wdata, host_rdata;
   logic          host_rdy, dir_bit, init_req, to_clear, to_sticky;
   logic [TW-1:0] to_limit;
   logic [DW-1:0] pd_in, pd_out;
   logic          pd_oe, pp_wr_n, pp_dstb_n, pp_astb_n, pp_wait_n, pp_rx_dir, pp_init_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   epp_cycle_ctrl #(.DW(DW), .TW(TW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_is_addr(host_is_addr),
      .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rdy(host_rdy), .dir_bit(dir_bit),
      .init_req(init_req), .to_limit(to_limit), .to_clear(to_clear),
      .to_sticky(to_sticky), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
      .pp_wr_n(pp_wr_n), .pp_dstb_n(pp_dstb_n), .pp_astb_n(pp_astb_n),
      .pp_wait_n(pp_wait_n), .pp_rx_dir(pp_rx_dir), .pp_init_n(pp_init_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycle(input bit rd, input bit adr, input bit dirb,
                            input logic [7:0] wd, input logic [7:0] rb,
                            input int d, input int lim);
      bit   exp_to;
      int   expk;
      int   k;
      bit   got;
      bit   drv;
      logic wr_setup;
      exp_to = (lim < d + 2);
      expk   = exp_to ? lim + 1 : d + 3;
      drv    = !rd && !dirb;
      @(negedge clk);
      dir_bit = dirb; to_limit = lim[TW-1:0]; pd_in = rb;
      host_is_addr = adr; host_wdata = wd; host_sel = 1'b1;
      if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
      @(negedge clk);
      // setup cycle
      chk(host_rdy == 1'b0, "R4 setup stall", host_rdy, 0);
      chk(pp_dstb_n && pp_astb_n, "R2 no strobe in setup", {pp_dstb_n, pp_astb_n}, 3);
      chk(pp_rx_dir == (rd | dirb), "R10 direction", pp_rx_dir, rd | dirb);
      chk(pd_oe == drv, "R3 drive in setup", pd_oe, drv);
      chk(pp_wr_n == !drv, "R3 write marker in setup", pp_wr_n, !drv);
      if (drv) chk(pd_out == wd, "R3 write data", pd_out, wd);
      wr_setup = pp_wr_n;
      @(negedge clk);
      // index 0: strobe just fell
      if (adr) chk(!pp_astb_n && pp_dstb_n, "R2 address strobe", {pp_dstb_n, pp_astb_n}, 2);
      else     chk(!pp_dstb_n && pp_astb_n, "R2 data strobe", {pp_dstb_n, pp_astb_n}, 1);
      chk(pp_wr_n == wr_setup, "R3 marker stable at strobe", pp_wr_n, wr_setup);
      got = 1'b0; k = -1;
      for (int i = 0; i < 40; i++) begin
         if (i == d) pp_wait_n = 1'b1;
         if (!got && host_rdy) begin got = 1'b1; k = i; end
         if (got && i >= d) break;
         @(negedge clk);
      end
      if (lim == d + 2) chk(k == expk, "R7 release index on collision", k, expk);
      else              chk(k == expk, "R4 release index", k, expk);
      if (lim == d + 2) chk(to_sticky == 1'b0, "R7 rise wins flag", to_sticky, 0);
      else              chk(to_sticky == exp_to, "R6 timeout flag", to_sticky, exp_to);
      if (rd) chk(host_rdata == (exp_to ? 8'hFF : rb), "R5 R6 read data",
                  host_rdata, exp_to ? 8'hFF : rb);
      else    chk(host_rdata == 8'h00, "R5 no data on write", host_rdata, 0);
      if (drv) chk(pd_oe && pd_out == wd, "R3 drive held", pd_out, wd);
      else     chk(!pd_oe && pp_wr_n, "R10 no drive", pd_oe, 0);
      @(negedge clk);
      chk(!(pp_dstb_n && pp_astb_n), "R8 strobe held", {pp_dstb_n, pp_astb_n}, adr ? 2 : 1);
      host_rd_n = 1'b1; host_wr_n = 1'b1; host_sel = 1'b0;
      @(negedge clk);
      chk(pp_dstb_n && pp_astb_n, "R8 strobes released", {pp_dstb_n, pp_astb_n}, 3);
      chk(!pd_oe && pp_wr_n, "R8 drive released", pd_oe, 0);
      chk(host_rdy && host_rdata == 8'h00, "R8 host idle", host_rdata, 0);
      chk(pp_rx_dir == dirb, "R10 direction at rest", pp_rx_dir, dirb);
      chk(to_sticky == exp_to, "R9 flag persists", to_sticky, exp_to);
      pp_wait_n = 1'b0; to_clear = 1'b1;
      @(negedge clk);
      to_clear = 1'b0;
      chk(to_sticky == 1'b0, "R9 flag cleared", to_sticky, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; host_sel = 1'b0; host_is_addr = 1'b0; host_rd_n = 1'b1;
      host_wr_n = 1'b1; host_wdata = '0; dir_bit = 1'b0; init_req = 1'b0;
      to_limit = '0; to_clear = 1'b0; pd_in = '0; pp_wait_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(pp_dstb_n && pp_astb_n, "R1 strobes idle", {pp_dstb_n, pp_astb_n}, 3);
      chk(host_rdy == 1'b1, "R1 ready", host_rdy, 1);
      chk(!pd_oe && pp_wr_n, "R1 no drive", pd_oe, 0);
      chk(to_sticky == 1'b0, "R1 flag", to_sticky, 0);
      chk(pp_init_n == 1'b0, "R1 peripheral reset", pp_init_n, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pp_init_n == 1'b1, "R12 init idle", pp_init_n, 1);
      init_req = 1'b1;
      @(negedge clk);
      chk(pp_init_n == 1'b0, "R12 init asserted", pp_init_n, 0);
      init_req = 1'b0;
      @(negedge clk);
      chk(pp_init_n == 1'b1, "R12 init released", pp_init_n, 1);
      repeat (2) @(negedge clk);

      // R11: command without select
      host_sel = 1'b0; host_rd_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(pp_dstb_n && pp_astb_n && host_rdy, "R11 unselected ignored",
             {pp_dstb_n, pp_astb_n, host_rdy}, 7);
      end
      host_rd_n = 1'b1;
      @(negedge clk);

      for (int rd = 0; rd < 2; rd++)
         for (int dirb = 0; dirb < 2; dirb++)
            for (int adr = 0; adr < 2; adr++)
               for (int d = 0; d < 5; d++)
                  for (int lim = 0; lim < 8; lim++)
                     run_cycle(rd[0], adr[0], dirb[0],
                               8'((d * 37 + lim * 11 + adr * 5) ^ 8'h5A),
                               8'((lim * 29 + d * 13 + rd) ^ 8'hC3), d, lim);

      summary();
      $finish;
   end
endmodule